// File: doc/BRIEF.md
# Expansion-Slot Channel-Check Scanner

When a non-maskable error event arrives, this sequencer finds which expansion adapter raised a channel check. It masters a byte-wide register port that uses a request/acknowledge handshake. It first turns motherboard setup mode off. It then selects every slot in turn and reads that slot's check-status configuration register. For a slot whose check flag is active, it may also fetch two extended status bytes.

Each slot found in check is reported on a one-cycle report strobe. The report carries a one-based slot number and, when the adapter offers them, the two extended status bytes. At the end of the scan the adapter selection is cleared and a one-cycle done pulse is raised. The done pulse comes with a bitmap of the flagged slots. If no slot is flagged, a fallback output tells the error handler to look at the non-slot error source.

Top module: `chk_scan_top`

## Requirements
- R1: After reset, `busy`, `bus_req`, `rpt_valid`, `done` and `fallback` are low and `flag_map` is all zeros.
- R2: The first access of every scan writes 0xFF to the motherboard setup address (default 0x0094).
- R3: Slots are visited in ascending index order from 0 to NSLOT-1. Each visit is a write of (index OR 0x08) to the adapter setup address (default 0x0096), followed by a read of configuration register 5 at POS_BASE+5 (default 0x0105).
- R4: A slot is flagged exactly when bit 7 of its register 5 reads 0. Each flagged slot produces one `rpt_valid` cycle, with `rpt_slot` equal to index+1. Reports come in index order.
- R5: For a flagged slot whose register-5 bit 6 reads 0, registers 6 and 7 are read in that order (POS_BASE+6, then POS_BASE+7). The report then carries `rpt_ext`=1, with `rpt_stat_a` holding register 6 and `rpt_stat_b` holding register 7. Otherwise no extended reads are made and `rpt_ext`=0.
- R6: Bit 6 of register 5 causes no extended reads when bit 7 is 1. Flagging one slot does not stop the scan of the remaining slots.
- R7: After the last slot, 0x00 is written to the adapter setup address. Then `done` is high for exactly one cycle, with `flag_map` bit i set exactly when slot i was flagged.
- R8: `fallback` is high only in the `done` cycle, and only when no slot was flagged.
- R9: `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` held stable until the cycle in which `bus_ack` is sampled high. No new access begins before that cycle.
- R10: `busy` is high from the cycle after `start` is accepted up to and including the `done` cycle. A `start` that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Error event; begins a scan when idle |
| busy | output | 1 | Scan in progress |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete (read data valid) |
| bus_rdata | input | 8 | Read data |
| rpt_valid | output | 1 | One-cycle report of a flagged slot |
| rpt_slot | output | $clog2(NSLOT+1) | Flagged slot number (index+1) |
| rpt_ext | output | 1 | Extended status bytes are valid |
| rpt_stat_a | output | 8 | Register 6 of the flagged slot |
| rpt_stat_b | output | 8 | Register 7 of the flagged slot |
| done | output | 1 | One-cycle end-of-scan pulse |
| flag_map | output | NSLOT | Bitmap of flagged slots, complete at `done` |
| fallback | output | 1 | No slot flagged; error is from the non-slot source |

## Verification
Two cases are the hardest to reach from the ports. The first is a slot whose status-available bit reads low while its check bit reads high: R6 requires that this causes no extended reads. The second is a fresh error event arriving in the middle of a scan. The bench's register responder models the slot register files and honours the current adapter selection. It acknowledges each access after a random delay, so both cases can be set up directly: directed slot images give the mismatched flag combinations, and a second `start` pulse is issued while a scan is under way. Random slot images then cover mixed flagged, extended and clean slots. Each scan's whole access trace is compared with a trace computed from the images.

// File: rtl/chk_scan_pkg.sv
package chk_scan_pkg;

    // Configuration register numbers inside a selected adapter
    localparam int unsigned REG_CHECK = 5;
    localparam int unsigned REG_EXT_A = 6;
    localparam int unsigned REG_EXT_B = 7;

    // Bit positions inside the check register (active low)
    localparam int unsigned BIT_CHECK_N = 7;
    localparam int unsigned BIT_STAT_N  = 6;

    // Adapter setup enable, ORed with the slot index
    localparam logic [7:0] ADAP_ENABLE  = 8'h08;
    localparam logic [7:0] MB_SETUP_OFF = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MB_OFF,
        ST_SELECT,
        ST_RD_CHECK,
        ST_RD_EXT_A,
        ST_RD_EXT_B,
        ST_REPORT,
        ST_DESELECT,
        ST_FIN
    } scan_state_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MB_WR,
        ACC_SEL_WR,
        ACC_DESEL_WR,
        ACC_RD_CHECK,
        ACC_RD_EXT_A,
        ACC_RD_EXT_B
    } access_e;

    typedef struct packed {
        logic       has_ext;
        logic [7:0] ext_a;
        logic [7:0] ext_b;
    } slot_status_t;

    function automatic access_e access_of(input scan_state_e st);
        case (st)
            ST_MB_OFF:   return ACC_MB_WR;
            ST_SELECT:   return ACC_SEL_WR;
            ST_RD_CHECK: return ACC_RD_CHECK;
            ST_RD_EXT_A: return ACC_RD_EXT_A;
            ST_RD_EXT_B: return ACC_RD_EXT_B;
            ST_DESELECT: return ACC_DESEL_WR;
            default:     return ACC_NONE;
        endcase
    endfunction

    function automatic logic [7:0] select_byte(input logic [7:0] idx);
        return (idx & 8'h07) | ADAP_ENABLE;
    endfunction

endpackage

// File: rtl/chk_scan_seq.sv
module chk_scan_seq
    import chk_scan_pkg::*;
#(
    parameter int unsigned NSLOT = 8,
    localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ack,
    input  logic              check_n,
    input  logic              stat_n,
    output scan_state_e       state,
    output logic [IDX_W-1:0]  slot,
    output logic              accept
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

    scan_state_e state_nx;
    logic [IDX_W-1:0] slot_nx;
    logic at_last;

    assign accept  = (state == ST_IDLE) && start;
    assign at_last = (slot == LAST_IDX);

    always_comb begin
        state_nx = state;
        slot_nx  = slot;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_MB_OFF;
                    slot_nx  = '0;
                end
            end
            ST_MB_OFF:   if (ack) state_nx = ST_SELECT;
            ST_SELECT:   if (ack) state_nx = ST_RD_CHECK;
            ST_RD_CHECK: begin
                if (ack) begin
                    if (!check_n) begin
                        state_nx = stat_n ? ST_REPORT : ST_RD_EXT_A;
                    end else if (at_last) begin
                        state_nx = ST_DESELECT;
                    end else begin
                        state_nx = ST_SELECT;
                        slot_nx  = slot + 1'b1;
                    end
                end
            end
            ST_RD_EXT_A: if (ack) state_nx = ST_RD_EXT_B;
            ST_RD_EXT_B: if (ack) state_nx = ST_REPORT;
            ST_REPORT: begin
                if (at_last) begin
                    state_nx = ST_DESELECT;
                end else begin
                    state_nx = ST_SELECT;
                    slot_nx  = slot + 1'b1;
                end
            end
            ST_DESELECT: if (ack) state_nx = ST_FIN;
            ST_FIN:      state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            state <= state_nx;
            slot  <= slot_nx;
        end
    end

endmodule

// File: rtl/chk_scan_bus.sv
module chk_scan_bus
    import chk_scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NSLOT = 8,
    parameter logic [ADDR_W-1:0] MB_SETUP_ADDR = 16'h0094,
    parameter logic [ADDR_W-1:0] ADAP_SETUP_ADDR = 16'h0096,
    parameter logic [ADDR_W-1:0] POS_BASE = 16'h0100,
    localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  scan_state_e        state,
    input  logic [IDX_W-1:0]   slot,
    output logic               req,
    output logic               we,
    output logic [ADDR_W-1:0]  addr,
    output logic [7:0]         wdata
);

    localparam logic [ADDR_W-1:0] ADDR_CHECK = POS_BASE + ADDR_W'(REG_CHECK);
    localparam logic [ADDR_W-1:0] ADDR_EXT_A = POS_BASE + ADDR_W'(REG_EXT_A);
    localparam logic [ADDR_W-1:0] ADDR_EXT_B = POS_BASE + ADDR_W'(REG_EXT_B);

    access_e kind;

    assign kind = access_of(state);

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (kind)
            ACC_MB_WR: begin
                we    = 1'b1;
                addr  = MB_SETUP_ADDR;
                wdata = MB_SETUP_OFF;
            end
            ACC_SEL_WR: begin
                we    = 1'b1;
                addr  = ADAP_SETUP_ADDR;
                wdata = select_byte(8'(slot));
            end
            ACC_DESEL_WR: begin
                we    = 1'b1;
                addr  = ADAP_SETUP_ADDR;
                wdata = 8'h00;
            end
            ACC_RD_CHECK: addr = ADDR_CHECK;
            ACC_RD_EXT_A: addr = ADDR_EXT_A;
            ACC_RD_EXT_B: addr = ADDR_EXT_B;
            default:      req  = 1'b0;
        endcase
    end

endmodule

// File: rtl/chk_scan_collect.sv
module chk_scan_collect
    import chk_scan_pkg::*;
#(
    parameter int unsigned NSLOT = 8,
    localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int unsigned CODE_W = $clog2(NSLOT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  scan_state_e        state,
    input  logic [IDX_W-1:0]   slot,
    input  logic               accept,
    input  logic               ack,
    input  logic [7:0]         rdata,
    output logic               rpt_valid,
    output logic [CODE_W-1:0]  rpt_slot,
    output slot_status_t       rpt_status,
    output logic [NSLOT-1:0]   flag_map,
    output logic               done,
    output logic               fallback
);

    slot_status_t cur_q;
    logic [NSLOT-1:0] map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            cur_q <= '0;
        end else begin
            if (accept) begin
                map_q <= '0;
            end
            if (ack) begin
                case (state)
                    ST_RD_CHECK: begin
                        if (!rdata[BIT_CHECK_N]) begin
                            map_q[slot]   <= 1'b1;
                            cur_q.has_ext <= !rdata[BIT_STAT_N];
                            cur_q.ext_a   <= '0;
                            cur_q.ext_b   <= '0;
                        end
                    end
                    ST_RD_EXT_A: cur_q.ext_a <= rdata;
                    ST_RD_EXT_B: cur_q.ext_b <= rdata;
                    default: ;
                endcase
            end
        end
    end

    assign rpt_valid  = (state == ST_REPORT);
    assign rpt_slot   = rpt_valid ? CODE_W'(slot) + 1'b1 : '0;
    assign rpt_status = rpt_valid ? cur_q : '0;
    assign flag_map   = map_q;
    assign done       = (state == ST_FIN);
    assign fallback   = done && (map_q == '0);

endmodule

// File: rtl/chk_scan_top.sv
module chk_scan_top
    import chk_scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NSLOT = 8,
    parameter logic [ADDR_W-1:0] MB_SETUP_ADDR = 16'h0094,
    parameter logic [ADDR_W-1:0] ADAP_SETUP_ADDR = 16'h0096,
    parameter logic [ADDR_W-1:0] POS_BASE = 16'h0100,
    localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int unsigned CODE_W = $clog2(NSLOT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [7:0]         bus_wdata,
    input  logic               bus_ack,
    input  logic [7:0]         bus_rdata,
    output logic               rpt_valid,
    output logic [CODE_W-1:0]  rpt_slot,
    output logic               rpt_ext,
    output logic [7:0]         rpt_stat_a,
    output logic [7:0]         rpt_stat_b,
    output logic               done,
    output logic [NSLOT-1:0]   flag_map,
    output logic               fallback
);

    scan_state_e      state;
    logic [IDX_W-1:0] slot;
    logic             accept;
    logic             ack_live;
    slot_status_t     status;

    // An acknowledge only counts while a request is outstanding
    assign ack_live = bus_ack && bus_req;

    chk_scan_seq #(.NSLOT(NSLOT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ack     (ack_live),
        .check_n (bus_rdata[BIT_CHECK_N]),
        .stat_n  (bus_rdata[BIT_STAT_N]),
        .state   (state),
        .slot    (slot),
        .accept  (accept)
    );

    chk_scan_bus #(
        .ADDR_W          (ADDR_W),
        .NSLOT           (NSLOT),
        .MB_SETUP_ADDR   (MB_SETUP_ADDR),
        .ADAP_SETUP_ADDR (ADAP_SETUP_ADDR),
        .POS_BASE        (POS_BASE)
    ) u_bus (
        .state (state),
        .slot  (slot),
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata)
    );

    chk_scan_collect #(.NSLOT(NSLOT)) u_col (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .slot       (slot),
        .accept     (accept),
        .ack        (ack_live),
        .rdata      (bus_rdata),
        .rpt_valid  (rpt_valid),
        .rpt_slot   (rpt_slot),
        .rpt_status (status),
        .flag_map   (flag_map),
        .done       (done),
        .fallback   (fallback)
    );

    assign busy       = (state != ST_IDLE);
    assign rpt_ext    = status.has_ext;
    assign rpt_stat_a = status.ext_a;
    assign rpt_stat_b = status.ext_b;

endmodule

// File: rtl/chk_scan_sva.sv
module chk_scan_sva #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NSLOT = 8,
    parameter logic [ADDR_W-1:0] MB_SETUP_ADDR = 16'h0094,
    localparam int unsigned CODE_W = $clog2(NSLOT + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [7:0]         bus_wdata,
    input logic               bus_ack,
    input logic               rpt_valid,
    input logic [CODE_W-1:0]  rpt_slot,
    input logic               done,
    input logic [NSLOT-1:0]   flag_map,
    input logic               fallback
);

    // R9: request and its fields held until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R2: scan opens with the motherboard setup disable write
    a_r2_first_access: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> bus_req && bus_we && bus_addr == MB_SETUP_ADDR && bus_wdata == 8'hFF);

    // R7: done lasts one cycle and no access is pending with it
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req && busy);

    // R8: fallback only at done with an empty map
    a_r8_fallback: assert property (@(posedge clk) disable iff (rst)
        fallback |-> done && flag_map == '0);

    // R4: a report names a flagged slot in range
    a_r4_report_slot: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> rpt_slot != '0 && rpt_slot <= CODE_W'(NSLOT) && flag_map[rpt_slot - 1'b1]);

    // R10: idle after done, requests only while busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    a_r10_req_busy: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy);

endmodule

bind chk_scan_top chk_scan_sva #(
    .ADDR_W        (ADDR_W),
    .NSLOT         (NSLOT),
    .MB_SETUP_ADDR (MB_SETUP_ADDR)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .rpt_valid (rpt_valid),
    .rpt_slot  (rpt_slot),
    .done      (done),
    .flag_map  (flag_map),
    .fallback  (fallback)
);

// File: tb/sim_chk_scan_top.sv
module sim_chk_scan_top;

    localparam int NS = 8;
    localparam logic [15:0] A_MB  = 16'h0094;
    localparam logic [15:0] A_SEL = 16'h0096;
    localparam logic [15:0] A_POS = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, bus_req, bus_we, bus_ack, rpt_valid, rpt_ext, done, fallback;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, rpt_stat_a, rpt_stat_b;
    logic [3:0] rpt_slot;
    logic [NS-1:0] flag_map;

    always #5 clk = ~clk;

    chk_scan_top u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rpt_valid(rpt_valid), .rpt_slot(rpt_slot), .rpt_ext(rpt_ext),
        .rpt_stat_a(rpt_stat_a), .rpt_stat_b(rpt_stat_b),
        .done(done), .flag_map(flag_map), .fallback(fallback)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // slot register images
    logic [7:0] m5 [NS];
    logic [7:0] m6 [NS];
    logic [7:0] m7 [NS];

    // observed trace
    logic        o_we   [64];
    logic [15:0] o_addr [64];
    logic [7:0]  o_data [64];
    int o_n = 0;
    int r_n = 0;
    logic [3:0] r_slot [16];
    logic       r_ext  [16];
    logic [7:0] r_a    [16];
    logic [7:0] r_b    [16];
    int done_cnt = 0;
    logic [NS-1:0] cap_map;
    logic cap_fb;
    int hs_bad = 0;

    // responder and monitor
    logic [7:0] sel_reg = 8'h00;
    int wait_n = 0;
    bit tracking = 0;
    logic        t_we;
    logic [15:0] t_addr;
    logic [7:0]  t_data;

    function automatic logic [7:0] rd_val(input logic [15:0] a, input logic [7:0] s);
        if (!s[3]) return 8'h00;
        if (a == A_POS + 16'd5) return m5[s[2:0]];
        if (a == A_POS + 16'd6) return m6[s[2:0]];
        if (a == A_POS + 16'd7) return m7[s[2:0]];
        return 8'h00;
    endfunction

    initial begin
        bus_ack = 1'b0;
        bus_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (done) begin
                done_cnt++;
                cap_map = flag_map;
                cap_fb = fallback;
            end
            if (rpt_valid && r_n < 16) begin
                r_slot[r_n] = rpt_slot;
                r_ext[r_n] = rpt_ext;
                r_a[r_n] = rpt_stat_a;
                r_b[r_n] = rpt_stat_b;
                r_n++;
            end
            if (bus_ack) begin
                bus_ack = 1'b0;
                tracking = 0;
            end else if (bus_req) begin
                if (!tracking) begin
                    tracking = 1;
                    t_we = bus_we; t_addr = bus_addr; t_data = bus_wdata;
                    wait_n = $urandom % 4;
                end else if (bus_we !== t_we || bus_addr !== t_addr || bus_wdata !== t_data) begin
                    hs_bad++;
                end
                if (wait_n == 0) begin
                    bus_ack = 1'b1;
                    bus_rdata = bus_we ? 8'h00 : rd_val(bus_addr, sel_reg);
                    if (bus_we && bus_addr == A_SEL) sel_reg = bus_wdata;
                    if (o_n < 64) begin
                        o_we[o_n] = bus_we; o_addr[o_n] = bus_addr; o_data[o_n] = bus_wdata;
                        o_n++;
                    end
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // expected trace
    logic        e_we   [64];
    logic [15:0] e_addr [64];
    logic [7:0]  e_data [64];
    logic [1:0]  e_cls  [64]; // 0 R2, 1 R3, 2 R5, 3 R7
    int e_n;

    task automatic push(input logic w, input logic [15:0] a, input logic [7:0] d, input logic [1:0] c);
        e_we[e_n] = w; e_addr[e_n] = a; e_data[e_n] = d; e_cls[e_n] = c;
        e_n++;
    endtask

    task automatic run_scan(input string name, input bit restart_mid);
        int mism [4];
        int k;
        int exp_r;
        logic [NS-1:0] emap;
        bit rep_ok;
        for (int c = 0; c < 4; c++) mism[c] = 0;
        e_n = 0;
        emap = '0;
        push(1'b1, A_MB, 8'hFF, 2'd0);
        for (int i = 0; i < NS; i++) begin
            push(1'b1, A_SEL, 8'(i) | 8'h08, 2'd1);
            push(1'b0, A_POS + 16'd5, 8'h00, 2'd1);
            if (!m5[i][7]) begin
                emap[i] = 1'b1;
                if (!m5[i][6]) begin
                    push(1'b0, A_POS + 16'd6, 8'h00, 2'd2);
                    push(1'b0, A_POS + 16'd7, 8'h00, 2'd2);
                end
            end
        end
        push(1'b1, A_SEL, 8'h00, 2'd3);

        o_n = 0; r_n = 0; done_cnt = 0; hs_bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", busy, 1);
        k = 0;
        while (done_cnt == 0 && k < 3000) begin
            @(negedge clk);
            k++;
            if (restart_mid && k == 12) start = 1'b1;
            if (restart_mid && k == 13) start = 1'b0;
        end
        repeat (6) @(negedge clk);
        $display("[TB] scan %s", name);

        chk(o_n == e_n, "R3 access count", o_n, e_n);
        for (int j = 0; j < e_n && j < o_n; j++) begin
            if (o_we[j] !== e_we[j] || o_addr[j] !== e_addr[j] ||
                (e_we[j] && o_data[j] !== e_data[j]))
                mism[e_cls[j]]++;
        end
        chk(mism[0] == 0, "R2 setup disable write", mism[0], 0);
        chk(mism[1] == 0, "R3 select and check read", mism[1], 0);
        chk(mism[2] == 0, "R5 R6 extended reads", mism[2], 0);
        chk(mism[3] == 0, "R7 deselect write", mism[3], 0);
        chk(hs_bad == 0, "R9 fields stable under request", hs_bad, 0);

        exp_r = 0;
        rep_ok = 1;
        for (int i = 0; i < NS; i++) begin
            if (emap[i]) begin
                if (exp_r >= r_n) rep_ok = 0;
                else begin
                    if (r_slot[exp_r] != 4'(i + 1)) rep_ok = 0;
                    if (r_ext[exp_r] != !m5[i][6]) rep_ok = 0;
                    if (!m5[i][6] && (r_a[exp_r] != m6[i] || r_b[exp_r] != m7[i])) rep_ok = 0;
                end
                exp_r++;
            end
        end
        chk(r_n == exp_r, "R4 report count", r_n, exp_r);
        chk(rep_ok, "R4 R5 report contents", rep_ok, 1);
        chk(done_cnt == 1, "R7 R10 single done", done_cnt, 1);
        chk(cap_map == emap, "R7 flag map", cap_map, emap);
        chk(cap_fb == (emap == '0), "R8 fallback", cap_fb, (emap == '0));
        chk(busy === 1'b0, "R10 idle after done", busy, 0);
    endtask

    task automatic fill(input logic [7:0] v5, input logic [7:0] v6, input logic [7:0] v7);
        for (int i = 0; i < NS; i++) begin
            m5[i] = v5; m6[i] = v6 ^ 8'(i); m7[i] = v7 + 8'(i);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        fill(8'hFF, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !bus_req && !rpt_valid && !done && !fallback && flag_map == '0,
            "R1 reset outputs", {busy, bus_req, rpt_valid, done, fallback, flag_map}, 0);

        fill(8'hFF, 8'h00, 8'h00);
        run_scan("none flagged", 0);                 // R8 fallback
        fill(8'h3F, 8'hA0, 8'h50);
        run_scan("all flagged with ext", 0);         // R5
        fill(8'hFF, 8'h00, 8'h00);
        m5[0] = 8'h7F;
        run_scan("slot 0 only, no ext", 0);          // R4
        fill(8'hFF, 8'h00, 8'h00);
        m5[7] = 8'h3E; m6[7] = 8'hC3; m7[7] = 8'h5A;
        run_scan("slot 7 only, ext", 0);             // R4 R5
        fill(8'hBF, 8'h11, 8'h22);
        run_scan("status low, check high", 0);       // R6
        fill(8'hFF, 8'h00, 8'h00);
        m5[2] = 8'h3F; m5[5] = 8'h7F;
        run_scan("restart while busy", 1);           // R10
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < NS; i++) begin
                m5[i] = 8'($urandom);
                if (($urandom % 3) != 0) m5[i][7] = 1'b1;
                m6[i] = 8'($urandom);
                m7[i] = 8'($urandom);
            end
            run_scan("random", (t % 5) == 4);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule